// File: doc/BRIEF.md
# Daisy-Chained DMA Access Requester

This block lets a device's internal logic win a shared memory bus that is handed out over a daisy-chained grant line. The internal logic raises a need-access level together with a word count. The block then pulls an active-low request toward the arbiter. It waits for the grant, takes it, and holds the bus for the whole transfer. If a grant arrives while the block has nothing to do, the block passes it straight down the chain to the next device.

While the block owns the bus it drives an active-low acknowledge and an active-low three-state control. The host must float its address and data buffers while the three-state control is low. A burst flag is high during any cycle that moves two or more words. A burst cycle moves at most five data words and then one dummy word. All sequencing runs on a clock-enable that stands for a half-rate clock: state, and therefore every registered output, changes only on clock edges where the enable is high.

Top module: `dma_chain_ctrl`

## Requirements
- R1: At reset, request, acknowledge, three-state control and grant-out are high (inactive, with the grant input high), and burst and clip-error are low.
- R2: An enable edge with need_i high and a nonzero words_i drives req_n_o low from that edge on.
- R3: On the first enable edge in the requesting state where grant_n_i is low, req_n_o returns high and ack_n_o goes low. Acknowledge never goes low unless request was low just before, and both are never low together.
- R4: grant_out_n_o equals grant_n_i, with no register delay, only while the block is idle. Once a request is pending and until the transfer has ended, it is held high.
- R5: ack_n_o stays low for one enable period per data word, plus one more period for the dummy word of a burst. It then returns high for at least one period before a new request can be raised.
- R6: tsctl_n_o is low exactly while ack_n_o is low, so both go back high on the same edge.
- R7: burst_o is high throughout the acknowledge window of a transfer of two or more words, and low for a single-word transfer and outside transfers.
- R8: A single-word transfer has no dummy word; its acknowledge window is exactly one enable period.
- R9: A words_i value of zero is ignored: no request is raised and the grant keeps being forwarded.
- R10: A words_i value above five is clipped to five data words. clip_err_o is high for exactly one enable period, starting at the edge that accepts the request.
- R11: Registered outputs do not change on clock edges where half_en_i is low, even when grant_n_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en_i | input | 1 | Clock-enable marking the half-rate clock edges |
| need_i | input | 1 | Internal logic needs memory access (level) |
| words_i | input | IN_W | Requested number of data words |
| grant_n_i | input | 1 | Incoming chained grant, active low |
| req_n_o | output | 1 | Bus request to the arbiter, active low |
| grant_out_n_o | output | 1 | Grant passed to the next device, active low |
| ack_n_o | output | 1 | Grant acknowledge, held for the whole transfer, active low |
| tsctl_n_o | output | 1 | Memory-ownership strobe for host buffer three-stating, active low |
| burst_o | output | 1 | Current transfer moves two or more words |
| clip_err_o | output | 1 | Requested count was above the maximum and was clipped |

## Verification
The request, acknowledge, three-state, burst and clip-error outputs change on the enable edge that samples their cause. They are visible right after that edge, so each result is due one enable edge after its stimulus. The forwarded grant is combinational and is due in the same cycle as the grant input. The bench drives inputs at a falling clock edge and advances with a task that raises the enable for exactly one rising edge. It samples every registered result at the falling edge right after that enable edge. It checks the forwarded grant before any edge. The acknowledge window is measured by counting enable periods, and one probe changes the grant on a non-enable edge to show that nothing moves there.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_ACCESS  = 3'd2,
        ST_DUMMY   = 3'd3,
        ST_RELEASE = 3'd4
    } chain_state_e;

endpackage

// File: rtl/dma_count_clip.sv
module dma_count_clip #(
    parameter int IN_W      = 4,
    parameter int MAX_WORDS = 5,
    parameter int CNT_W     = 3
) (
    input  logic [IN_W-1:0]  words_i,
    output logic             zero_o,
    output logic             clipped_o,
    output logic [CNT_W-1:0] words_o
);

    localparam logic [IN_W-1:0]  MAX_IN  = IN_W'(MAX_WORDS);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_WORDS);

    always_comb begin
        zero_o    = (words_i == '0);
        clipped_o = (words_i > MAX_IN);
        words_o   = clipped_o ? MAX_CNT : CNT_W'(words_i);
    end

endmodule

// File: rtl/dma_word_timer.sv
module dma_word_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic             last_o
);

    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load_i) begin
            rem_d = load_val_i;
        end else if (step_i && rem_q != '0) begin
            rem_d = rem_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign last_o = (rem_q == CNT_W'(1));

endmodule

// File: rtl/dma_grant_pass.sv
module dma_grant_pass (
    input  logic grant_n_i,
    input  logic idle_i,
    output logic grant_out_n_o
);

    always_comb begin
        grant_out_n_o = grant_n_i | ~idle_i;
    end

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
    parameter int IN_W      = 4,
    parameter int MAX_WORDS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            half_en_i,
    input  logic            need_i,
    input  logic [IN_W-1:0] words_i,
    input  logic            grant_n_i,
    output logic            req_n_o,
    output logic            grant_out_n_o,
    output logic            ack_n_o,
    output logic            tsctl_n_o,
    output logic            burst_o,
    output logic            clip_err_o
);
    import dma_chain_pkg::*;

    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        chain_state_e     state;
        logic [CNT_W-1:0] words;
        logic             burst;
        logic             clip;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic             cnt_zero;
    logic             cnt_clipped;
    logic [CNT_W-1:0] cnt_words;
    logic             timer_load;
    logic             timer_step;
    logic             timer_last;
    logic             owning;

    dma_count_clip #(
        .IN_W      (IN_W),
        .MAX_WORDS (MAX_WORDS),
        .CNT_W     (CNT_W)
    ) u_clip (
        .words_i   (words_i),
        .zero_o    (cnt_zero),
        .clipped_o (cnt_clipped),
        .words_o   (cnt_words)
    );

    assign timer_load = half_en_i && (r_q.state == ST_REQ) && !grant_n_i;
    assign timer_step = half_en_i && (r_q.state == ST_ACCESS);

    dma_word_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (r_q.words),
        .step_i     (timer_step),
        .last_o     (timer_last)
    );

    dma_grant_pass u_pass (
        .grant_n_i     (grant_n_i),
        .idle_i        (r_q.state == ST_IDLE),
        .grant_out_n_o (grant_out_n_o)
    );

    always_comb begin
        r_d = r_q;
        if (half_en_i) begin
            r_d.clip = 1'b0;
            unique case (r_q.state)
                ST_IDLE: begin
                    if (need_i && !cnt_zero) begin
                        r_d.state = ST_REQ;
                        r_d.words = cnt_words;
                        r_d.burst = (cnt_words >= CNT_W'(2));
                        r_d.clip  = cnt_clipped;
                    end
                end
                ST_REQ: begin
                    if (!grant_n_i) begin
                        r_d.state = ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (timer_last) begin
                        r_d.state = r_q.burst ? ST_DUMMY : ST_RELEASE;
                    end
                end
                ST_DUMMY: begin
                    r_d.state = ST_RELEASE;
                end
                ST_RELEASE: begin
                    r_d.state = ST_IDLE;
                end
                default: begin
                    r_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, words: '0, burst: 1'b0, clip: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign owning     = (r_q.state == ST_ACCESS) || (r_q.state == ST_DUMMY);
    assign req_n_o    = (r_q.state != ST_REQ);
    assign ack_n_o    = ~owning;
    assign tsctl_n_o  = ~owning;
    assign burst_o    = owning && r_q.burst;
    assign clip_err_o = r_q.clip;

endmodule

// File: rtl/dma_chain_ctrl_chk.sv
module dma_chain_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic half_en_i,
    input logic req_n_o,
    input logic grant_out_n_o,
    input logic ack_n_o,
    input logic tsctl_n_o,
    input logic burst_o,
    input logic clip_err_o
);

    assert_req_ack_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!req_n_o && !ack_n_o));

    assert_ack_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> !$past(req_n_o));

    assert_fwd_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_out_n_o |-> (req_n_o && ack_n_o));

    assert_ts_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tsctl_n_o == ack_n_o);

    assert_burst_in_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> !ack_n_o);

    assert_hold_off_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en_i |=> ($stable(req_n_o) && $stable(ack_n_o) &&
                        $stable(burst_o) && $stable(clip_err_o)));

endmodule

bind dma_chain_ctrl dma_chain_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .half_en_i     (half_en_i),
    .req_n_o       (req_n_o),
    .grant_out_n_o (grant_out_n_o),
    .ack_n_o       (ack_n_o),
    .tsctl_n_o     (tsctl_n_o),
    .burst_o       (burst_o),
    .clip_err_o    (clip_err_o)
);

// File: tb/tb_dma_chain_ctrl.sv
module tb_dma_chain_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_en = 1'b0;
    logic       need = 1'b0;
    logic [3:0] words = 4'd0;
    logic       grant_n = 1'b1;
    logic       req_n, grant_out_n, ack_n, tsctl_n, burst, clip_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dma_chain_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_en_i     (half_en),
        .need_i        (need),
        .words_i       (words),
        .grant_n_i     (grant_n),
        .req_n_o       (req_n),
        .grant_out_n_o (grant_out_n),
        .ack_n_o       (ack_n),
        .tsctl_n_o     (tsctl_n),
        .burst_o       (burst),
        .clip_err_o    (clip_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk) half_en = 1'b1;
        @(negedge clk) half_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 req_n", int'(req_n), 1);
        check("R1 ack_n", int'(ack_n), 1);
        check("R1 tsctl_n", int'(tsctl_n), 1);
        check("R1 grant_out_n", int'(grant_out_n), 1);
        check("R1 burst", int'(burst), 0);
        check("R1 clip_err", int'(clip_err), 0);
    endtask

    task automatic t_xfer(input int w_in, input int w_exp, input int clip_exp);
        int win;
        int exp_win;
        need  = 1'b1;
        words = 4'(w_in);
        step();
        check("R2 req_n low after need", int'(req_n), 0);
        check("R10 clip_err at accept", int'(clip_err), clip_exp);
        need = 1'b0;
        grant_n = 1'b0;
        @(negedge clk);
        check("R11 no move off enable", int'(ack_n), 1);
        check("R11 req held off enable", int'(req_n), 0);
        grant_n = 1'b1;
        step();
        check("R10 clip_err one period", int'(clip_err), 0);
        check("R3 still waiting for grant", int'(req_n), 0);
        grant_n = 1'b0;
        #1;
        check("R4 grant blocked while pending", int'(grant_out_n), 1);
        step();
        check("R3 req released on grant", int'(req_n), 1);
        check("R3 ack low on grant", int'(ack_n), 0);
        check("R6 tsctl with ack", int'(tsctl_n), 0);
        check("R7 burst flag", int'(burst), (w_exp >= 2) ? 1 : 0);
        check("R4 grant blocked in access", int'(grant_out_n), 1);
        grant_n = 1'b1;
        win = 1;
        for (int g = 0; g < 12 && ack_n == 1'b0; g++) begin
            step();
            if (ack_n == 1'b0) begin
                win++;
                check("R7 burst held in window", int'(burst), (w_exp >= 2) ? 1 : 0);
            end
        end
        exp_win = w_exp + ((w_exp >= 2) ? 1 : 0);
        if (w_exp == 1) check("R8 single word window", win, 1);
        check("R5 ack window length", win, exp_win);
        check("R6 tsctl released with ack", int'(tsctl_n), 1);
        check("R7 burst low after", int'(burst), 0);
        check("R5 release req stays high", int'(req_n), 1);
        step();
        check("R5 back to idle", int'(req_n), 1);
    endtask

    task automatic t_zero();
        need  = 1'b1;
        words = 4'd0;
        step();
        step();
        check("R9 zero count no request", int'(req_n), 1);
        grant_n = 1'b0;
        #1;
        check("R4 grant forwarded in idle", int'(grant_out_n), 0);
        check("R9 zero count grant forwarded", int'(ack_n), 1);
        grant_n = 1'b1;
        #1;
        check("R4 forward follows input", int'(grant_out_n), 1);
        need = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_xfer(3, 3, 0);
        t_xfer(1, 1, 0);
        t_xfer(9, 5, 1);
        t_xfer(5, 5, 0);
        t_xfer(2, 2, 0);
        t_zero();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule